// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves an 18-bit word between two ports, A and B, with a separate storage path for each direction. The A-to-B path and the B-to-A path each have their own latch enable, their own data clock and their own output enable. A path can pass its input straight through, freeze the last value it saw, or pick up a new value when its data clock rises. The whole block runs on one system clock. The data clocks are ordinary inputs: the block samples them and looks for rising edges, so no inferred latches are needed.

Each port has separate input, output and per-bit output-enable vectors. A wrapper at chip level turns these into tri-state pins. The B port is driven from the A-to-B path under an active-high enable. The A port is driven from the B-to-A path under an active-low enable. An optional bus-hold keeper per port is selected by a parameter. When a port's input-valid qualifier is low, the keeper feeds the path the last word that was marked valid, so a floating bus never reaches the storage. The reset input is asynchronous and active low; the block releases it on the clock through a two-stage synchronizer.

Top module: `duplex_reg_xcvr`

## Requirements
- R1: While rst_n is low, and until the second rising clk edge after rst_n goes high, both stored words are zero, both output-enable vectors are all zeros, and each data output with its latch enable low reads zero.
- R2: When ab_le is 1, b_out equals the effective A input in the same cycle. At the next clk edge that word is also written into the A-to-B store.
- R3: When ab_le is 0 and ab_clk shows no rise, b_out keeps the stored word, whatever a_in does, and whether ab_clk is held at 1 or at 0.
- R4: When ab_le is 0 and ab_clk is 1 at a clk edge after being 0 at the previous edge, the A-to-B store takes the effective A input at that edge. b_out shows the new word from that edge on. The first edge after reset never counts as a rise.
- R5: When ab_le goes from 1 to 0 with ab_clk held at 1, the word kept is the effective A input sampled at the last clk edge at which ab_le was 1.
- R6: b_oe is all ones exactly when ab_oe is 1 and the block is out of reset. b_out carries the path value whether or not it is enabled.
- R7: a_oe is all ones exactly when ba_oe_n is 0 and the block is out of reset. a_out carries the B-to-A path value either way.
- R8: The B-to-A path obeys R2 to R5 using b_in, ba_le and ba_clk, with a_out as its output. It is fully independent of the A-to-B path, and both may pass through or capture in the same cycle.
- R9: With HOLD_EN=1, a cycle whose input-valid qualifier (a_in_vld or b_in_vld) is 0 feeds that path the last word presented with the qualifier at 1, or zero if there was none since reset. That cycle's port input has no effect on the output or on the store.
- R10: With HOLD_EN=0, the input-valid qualifiers have no effect and each path always uses its port input directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | 18 | Word arriving on port A (source of the A-to-B path) |
| a_in_vld | input | 1 | Port A input is being driven (used by the bus-hold keeper) |
| a_out | output | 18 | Word to drive onto port A from the B-to-A path |
| a_oe | output | 18 | Per-bit drive enable for port A |
| b_in | input | 18 | Word arriving on port B (source of the B-to-A path) |
| b_in_vld | input | 1 | Port B input is being driven (used by the bus-hold keeper) |
| b_out | output | 18 | Word to drive onto port B from the A-to-B path |
| b_oe | output | 18 | Per-bit drive enable for port B |
| ab_le | input | 1 | A-to-B latch enable, 1 = pass through |
| ab_clk | input | 1 | A-to-B data clock, captures on its rising edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 = pass through |
| ba_clk | input | 1 | B-to-A data clock, captures on its rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Both directions can act in the same cycle, and a keeper substitution can fall on the same cycle as a capture edge or a pass-through on its own path. The bench provokes the first case with directed cycles in which both latch enables are high, and then both data clocks rise together, each path carrying a different word. It provokes the second by lowering a qualifier while the same path is passing through. A long random phase then mixes all controls freely. Every cycle, a behavioural model of both paths and both keepers predicts all four outputs of a bus-hold instance and of a plain instance. Those predictions are compared with the actual outputs, so a cross-coupling between directions or a missed keeper substitution shows up as a mismatch on the exact cycle it occurs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Operation a storage element performs at the next system clock edge.
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_PASS = 2'd1,
    ST_EDGE = 2'd2
  } store_op_e;

  // Number of data directions carried by the transceiver.
  localparam int unsigned XCVR_DIRS = 2;

  // Pick the store operation: pass-through wins over an edge, an edge wins over hold.
  function automatic store_op_e pick_op(input logic le, input logic rise);
    if (le)        return ST_PASS;
    else if (rise) return ST_EDGE;
    else           return ST_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_r;
  logic [STAGES-1:0] sh_c;

  always_comb begin
    sh_c = {sh_r[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_r <= '0;
    else        sh_r <= sh_c;
  end

  assign rst_sync_n = sh_r[STAGES-1];

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int unsigned W       = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         vld,
  output logic [W-1:0] dout
);

  logic [W-1:0] keep_r;
  logic [W-1:0] keep_c;
  logic         keep_en;

  always_comb begin
    keep_en = vld;
    keep_c  = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       keep_r <= '0;
    else if (keep_en) keep_r <= keep_c;
  end

  generate
    if (HOLD_EN) begin : g_hold
      assign dout = vld ? din : keep_r;
    end else begin : g_plain
      assign dout = din;
    end
  endgenerate

  // R9: the keeper is frozen while the port is not driven
  a_r9_keep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(keep_r));

  // R9: the keeper follows a valid port word
  a_r9_keep_loads: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> keep_r == $past(din));

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         sclk,
  output logic [W-1:0] dout
);

  logic         sclk_q;
  logic         rise;
  store_op_e    op_c;
  logic         load_en;
  logic [W-1:0] q_r;
  logic [W-1:0] q_c;

  always_comb begin
    rise    = sclk & ~sclk_q;
    op_c    = pick_op(le, rise);
    load_en = (op_c != ST_HOLD);
    q_c     = load_en ? din : q_r;
  end

  // The previous data-clock sample resets high, so the first edge after reset is not a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      q_r    <= '0;
    end else begin
      sclk_q <= sclk;
      if (load_en) q_r <= q_c;
    end
  end

  assign dout = le ? din : q_r;

  // R2: pass-through also writes the store
  a_r2_pass_writes: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> q_r == $past(din));

  // R3: without latch enable and without a rise the store keeps its word
  a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !(sclk && !sclk_q)) |=> $stable(q_r));

  // R4: a data-clock rise captures the input
  a_r4_edge_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && sclk && !sclk_q) |=> q_r == $past(din));

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int unsigned W       = 18,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         din_vld,
  input  logic         le,
  input  logic         sclk,
  input  logic         oe_act,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);

  logic [W-1:0] din_eff;

  xcvr_keeper #(.W(W), .HOLD_EN(HOLD_EN)) keeper_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .vld   (din_vld),
    .dout  (din_eff)
  );

  xcvr_store #(.W(W)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din_eff),
    .le    (le),
    .sclk  (sclk),
    .dout  (dout)
  );

  // Drive enable is gated by the synchronised reset.
  assign oe = (rst_n && oe_act) ? {W{1'b1}} : '0;

endmodule

// File: rtl/duplex_reg_xcvr.sv
module duplex_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W          = 18,
  parameter bit          HOLD_EN    = 1'b1,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_in_vld,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic         b_in_vld,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n
);

  localparam int unsigned ND = XCVR_DIRS;

  logic          rst_sync_n;
  logic [W-1:0]  src_v [ND];
  logic [W-1:0]  dst_v [ND];
  logic [W-1:0]  oe_v  [ND];
  logic [ND-1:0] vld_v;
  logic [ND-1:0] le_v;
  logic [ND-1:0] sclk_v;
  logic [ND-1:0] act_v;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Direction 0 carries A to B, direction 1 carries B to A.
  assign src_v[0] = a_in;
  assign src_v[1] = b_in;
  assign vld_v    = {b_in_vld, a_in_vld};
  assign le_v     = {ba_le, ab_le};
  assign sclk_v   = {ba_clk, ab_clk};
  assign act_v    = {~ba_oe_n, ab_oe};

  generate
    for (genvar d = 0; d < ND; d++) begin : g_dir
      xcvr_dir #(.W(W), .HOLD_EN(HOLD_EN)) dir_i (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .din     (src_v[d]),
        .din_vld (vld_v[d]),
        .le      (le_v[d]),
        .sclk    (sclk_v[d]),
        .oe_act  (act_v[d]),
        .dout    (dst_v[d]),
        .oe      (oe_v[d])
      );
    end
  endgenerate

  assign b_out = dst_v[0];
  assign b_oe  = oe_v[0];
  assign a_out = dst_v[1];
  assign a_oe  = oe_v[1];

  // R6: B port is never driven while its enable is low
  a_r6_b_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ab_oe |-> b_oe == '0);

  // R7: A port enable is active low
  a_r7_a_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ba_oe_n |-> a_oe == '0);

  // R1: no port is driven during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

endmodule

// File: tb/duplex_reg_xcvr_tb_top.sv
module duplex_reg_xcvr_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         a_vld, b_vld, ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
  logic [W-1:0] h_a_out, h_a_oe, h_b_out, h_b_oe;
  logic [W-1:0] n_a_out, n_a_oe, n_b_out, n_b_oe;

  duplex_reg_xcvr #(.W(W), .HOLD_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_in_vld(a_vld), .a_out(h_a_out), .a_oe(h_a_oe),
    .b_in(b_in), .b_in_vld(b_vld), .b_out(h_b_out), .b_oe(h_b_oe), .ab_le(ab_le),
    .ab_clk(ab_clk), .ab_oe(ab_oe), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n));

  duplex_reg_xcvr #(.W(W), .HOLD_EN(1'b0)) dut_nh (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_in_vld(a_vld), .a_out(n_a_out), .a_oe(n_a_oe),
    .b_in(b_in), .b_in_vld(b_vld), .b_out(n_b_out), .b_oe(n_b_oe), .ab_le(ab_le),
    .ab_clk(ab_clk), .ab_oe(ab_oe), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n));

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // Behavioural model: index 0 = bus-hold instance, index 1 = plain instance.
  logic         live1, live2;
  logic [W-1:0] m_ab [2];
  logic [W-1:0] m_ba [2];
  logic [W-1:0] k_a, k_b;
  logic         prev_ab, prev_ba;

  function automatic logic [W-1:0] eff(input int inst, input logic [W-1:0] d, input logic v,
                                       input logic [W-1:0] k);
    return (inst == 0 && !v) ? k : d;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin live1 <= 1'b0; live2 <= 1'b0; end
    else begin live1 <= 1'b1; live2 <= live1; end

  always @(posedge clk or negedge live2) begin
    if (!live2) begin
      for (int i = 0; i < 2; i++) begin m_ab[i] <= '0; m_ba[i] <= '0; end
      k_a <= '0; k_b <= '0; prev_ab <= 1'b1; prev_ba <= 1'b1;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (ab_le || (ab_clk && !prev_ab)) m_ab[i] <= eff(i, a_in, a_vld, k_a);
        if (ba_le || (ba_clk && !prev_ba)) m_ba[i] <= eff(i, b_in, b_vld, k_b);
      end
      if (a_vld) k_a <= a_in;
      if (b_vld) k_b <= b_in;
      prev_ab <= ab_clk;
      prev_ba <= ba_clk;
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%05h expected=%05h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, well away from the active clock edge.
  always @(negedge clk) begin
    #2;
    if (rst_n !== 1'bx) begin
      for (int i = 0; i < 2; i++) begin
        logic [W-1:0] eb, ea, eob, eoa;
        eb  = ab_le ? eff(i, a_in, a_vld, k_a) : m_ab[i];
        ea  = ba_le ? eff(i, b_in, b_vld, k_b) : m_ba[i];
        eob = (live2 && ab_oe) ? {W{1'b1}} : '0;
        eoa = (live2 && !ba_oe_n) ? {W{1'b1}} : '0;
        chk(cur_req, i == 0 ? "hold b_out" : "plain b_out", i == 0 ? h_b_out : n_b_out, eb);
        chk(cur_req, i == 0 ? "hold a_out" : "plain a_out", i == 0 ? h_a_out : n_a_out, ea);
        chk(cur_req, i == 0 ? "hold b_oe"  : "plain b_oe",  i == 0 ? h_b_oe  : n_b_oe,  eob);
        chk(cur_req, i == 0 ? "hold a_oe"  : "plain a_oe",  i == 0 ? h_a_oe  : n_a_oe,  eoa);
      end
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_in = 18'h3FFFF; b_in = 18'h12345; a_vld = 1; b_vld = 1;
    ab_le = 0; ab_clk = 0; ab_oe = 1; ba_le = 0; ba_clk = 0; ba_oe_n = 0;
    // R1: reset with enables requested, outputs must be quiet and zero
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R2: pass-through A to B
    cur_req = "R2"; ab_le = 1; ab_clk = 1;
    a_in = 18'h00001; cyc(1); a_in = 18'h2AAAA; cyc(1); a_in = 18'h15555; cyc(1);
    a_in = 18'h2AAAA; cyc(1);
    // R5: drop latch enable with ab_clk high, then change data
    cur_req = "R5"; ab_le = 0; a_in = 18'h15555; cyc(1); a_in = 18'h00F0F; cyc(1);
    // R3: hold with ab_clk high, then low
    cur_req = "R3"; a_in = 18'h3C3C3; cyc(2); ab_clk = 0; a_in = 18'h0C0C0; cyc(2);
    // R4: rising data clock captures
    cur_req = "R4"; a_in = 18'h0F0F0; ab_clk = 1; cyc(1); a_in = 18'h11111; cyc(1);
    ab_clk = 0; a_in = 18'h22222; cyc(1); ab_clk = 1; cyc(1); a_in = 18'h33333; cyc(1);
    // R6: output disable, data still visible
    cur_req = "R6"; ab_oe = 0; cyc(2); ab_oe = 1; cyc(1);
    // R7: A port enable polarity
    cur_req = "R7"; ba_oe_n = 1; cyc(2); ba_oe_n = 0; cyc(1);
    // R8: both directions pass through, then capture, in the same cycles
    cur_req = "R8"; ab_clk = 0; ba_clk = 0; ab_le = 1; ba_le = 1;
    a_in = 18'h0ABCD; b_in = 18'h3DCBA; cyc(1);
    ab_le = 0; ba_le = 0; a_in = 18'h01234; b_in = 18'h05678; cyc(1);
    ab_clk = 1; ba_clk = 1; a_in = 18'h09999; b_in = 18'h06666; cyc(1);
    a_in = 18'h00000; b_in = 18'h3FFFF; cyc(2);
    // R9 R10: qualifier low while passing through and while capturing
    cur_req = "R9 R10"; ab_le = 1; ba_le = 1; a_in = 18'h1AAAA; b_in = 18'h25555; cyc(1);
    a_vld = 0; b_vld = 0; a_in = 18'h3F00F; b_in = 18'h000FF; cyc(2);
    ab_le = 0; ba_le = 0; ab_clk = 0; ba_clk = 0; cyc(1);
    ab_clk = 1; ba_clk = 1; a_in = 18'h12121; cyc(1);
    a_vld = 1; b_vld = 1; cyc(2);
    // R8: random mix of every control in both directions
    cur_req = "R8";
    for (int c = 0; c < 600; c++) begin
      a_in = 18'($urandom); b_in = 18'($urandom);
      a_vld = ($urandom % 4) != 0; b_vld = ($urandom % 4) != 0;
      ab_le = ($urandom % 4) == 0; ba_le = ($urandom % 4) == 0;
      ab_clk = $urandom % 2; ba_clk = $urandom % 2;
      ab_oe = $urandom % 2; ba_oe_n = $urandom % 2;
      cyc(1);
    end
    // R1: reset in mid-traffic
    cur_req = "R1"; ab_le = 0; ba_le = 0; rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule